// File: doc/BRIEF.md
# Serial EEPROM Word Reader (3-wire)

This block is a hardware master that fetches one 16-bit word from a small serial EEPROM over a 3-wire link. The link has a chip select, a serial clock and a data line into the memory, plus one data line back from it. The host side raises `start` for one cycle with a word address and a device-size select. The block then runs the whole read transaction by itself. It reports `busy` while the transaction runs and ends it with a one-cycle `done` strobe. At that point `rd_data` holds the word.

Two device sizes are handled at run time. The small one takes a 6-bit word address and the large one an 8-bit address. The transaction has a fixed shape. Select goes high and one idle clock pulse follows. Then come the read command `1,1,0` and the address, both first bit first, and the data line is held low. The memory drives a dummy zero first, and then 16 data clock pulses bring in the word, most significant bit first. Select is dropped and one final clock pulse follows. Every change on an output pin is held for a settle interval of `SETTLE_CYCLES` system clocks. That interval stands for a delay of about 10 µs in silicon and can be made short in simulation.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are low and `rd_data` is zero.
- R2: A `start` pulse while `busy` is low is accepted at that clock edge. One cycle later `busy` and `ee_cs` are high, and `ee_sk` is low.
- R3: With select high, one clock pulse with `ee_di` low comes before the command. The command is the bit sequence 1, 1, 0, and each bit is presented on `ee_di` at the rising edge of `ee_sk`.
- R4: The address follows the command, most significant bit first. With `wide_dev`=1 all 8 bits of `rd_addr` are sent. With `wide_dev`=0 only `rd_addr[5:0]` is sent and bits 7:6 have no effect. Both inputs are captured at acceptance.
- R5: `ee_di` and `ee_cs` never change while `ee_sk` is high.
- R6: After the address, `ee_di` stays low and exactly 16 data clock pulses follow. `ee_do` is sampled at the end of each low phase and shifted into `rd_data` from the most significant bit down. The memory's dummy zero is therefore never taken as data.
- R7: After the 16th data bit, `ee_cs` falls and one more `ee_sk` pulse follows with select low. The whole read has 27 rising edges of `ee_sk` for the small device and 29 for the large one.
- R8: Each level on the three output pins lasts at least `SETTLE_CYCLES` clock cycles during a read. Each `ee_sk` high phase lasts exactly `SETTLE_CYCLES`.
- R9: A `start` pulse while `busy` is high is ignored. It neither alters the running read nor causes an extra `done`.
- R10: `done` is a single-cycle pulse in the first cycle that `busy` is low again. `rd_data` then keeps its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle read request |
| rd_addr | input | 8 | Word address; bits 5:0 only for the small device |
| wide_dev | input | 1 | 1 = 8-bit address device, 0 = 6-bit address device |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse when `rd_data` is valid |
| rd_data | output | 16 | Word read from the memory |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data into the memory |
| ee_do | input | 1 | Serial data out of the memory |

## Verification
The hardest case to reach is the dummy zero that the memory inserts between the address and the data. A controller that samples one clock too early still returns a plausible word, shifted by one bit. The bench therefore contains a behavioural memory that watches rising edges of `ee_sk`. It ignores leading zeros and decodes the start and opcode bits. After the last address bit it drives the dummy zero, and only then does it drive the stored word from the most significant bit down. The stored contents have both edge bits set for some addresses, so a one-bit slip shows in the result. A second `start` issued in the middle of a read, and narrow reads with the upper address bits set, reach the ignore paths.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 8;
    localparam int NARROW_AW  = 6;
    localparam int OP_W       = 3;
    localparam logic [OP_W-1:0] READ_OP = 3'b110;
    localparam int SHIFT_W    = OP_W + ADDR_W;
    localparam int MAX_LEN    = (DATA_W > SHIFT_W) ? DATA_W : SHIFT_W;
    localparam int CNT_W      = $clog2(MAX_LEN);

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL,
        PH_PRE_HI,
        PH_PRE_LO,
        PH_SETUP,
        PH_CMD_HI,
        PH_CMD_LO,
        PH_QUIET,
        PH_DAT_HI,
        PH_DAT_LO,
        PH_DESEL,
        PH_POST_HI,
        PH_POST_LO
    } mw_phase_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } mw_pins_t;

    // Pin levels that belong to each phase; dbit is the pending command bit.
    function automatic mw_pins_t pins_for(mw_phase_e ph, logic dbit);
        mw_pins_t p;
        p = '0;
        case (ph)
            PH_SEL, PH_PRE_LO, PH_QUIET, PH_DAT_LO: p.cs = 1'b1;
            PH_PRE_HI, PH_DAT_HI: begin
                p.cs = 1'b1;
                p.sk = 1'b1;
            end
            PH_SETUP, PH_CMD_LO: begin
                p.cs = 1'b1;
                p.di = dbit;
            end
            PH_CMD_HI: begin
                p.cs = 1'b1;
                p.sk = 1'b1;
                p.di = dbit;
            end
            PH_POST_HI: p.sk = 1'b1;
            default: p = '0;
        endcase
        return p;
    endfunction

    // Command bits followed by the address, left-aligned for shifting out.
    function automatic logic [SHIFT_W-1:0] frame_for(logic [ADDR_W-1:0] a, logic wide);
        if (wide)
            return {READ_OP, a};
        return {READ_OP, a[NARROW_AW-1:0], {(ADDR_W-NARROW_AW){1'b0}}};
    endfunction

    // Number of command plus address bits, minus one.
    function automatic logic [CNT_W-1:0] frame_last(logic wide);
        if (wide)
            return CNT_W'(SHIFT_W - 1);
        return CNT_W'(OP_W + NARROW_AW - 1);
    endfunction

endpackage

// File: rtl/mw_settle_timer.sv
module mw_settle_timer #(
    parameter int SETTLE = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mw_sequencer.sv
module mw_sequencer
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic              tick,
    output logic              run,
    output logic              accept,
    output logic              take,
    output logic              finish,
    output mw_pins_t          pins
);
    mw_phase_e          ph, ph_n;
    logic [SHIFT_W-1:0] sr, sr_n;
    logic [CNT_W-1:0]   cnt, cnt_n;

    assign run = (ph != PH_IDLE);

    always_comb begin
        ph_n   = ph;
        sr_n   = sr;
        cnt_n  = cnt;
        accept = 1'b0;
        take   = 1'b0;
        finish = 1'b0;
        if (ph == PH_IDLE) begin
            if (start) begin
                accept = 1'b1;
                ph_n   = PH_SEL;
                sr_n   = frame_for(addr, wide);
                cnt_n  = frame_last(wide);
            end
        end else if (tick) begin
            case (ph)
                PH_SEL:     ph_n = PH_PRE_HI;
                PH_PRE_HI:  ph_n = PH_PRE_LO;
                PH_PRE_LO:  ph_n = PH_SETUP;
                PH_SETUP:   ph_n = PH_CMD_HI;
                PH_CMD_HI:  ph_n = PH_CMD_LO;
                PH_CMD_LO: begin
                    sr_n = sr << 1;
                    if (cnt == '0) begin
                        ph_n  = PH_QUIET;
                        cnt_n = CNT_W'(DATA_W - 1);
                    end else begin
                        ph_n  = PH_SETUP;
                        cnt_n = cnt - 1'b1;
                    end
                end
                PH_QUIET:   ph_n = PH_DAT_HI;
                PH_DAT_HI:  ph_n = PH_DAT_LO;
                PH_DAT_LO: begin
                    take = 1'b1;
                    if (cnt == '0) begin
                        ph_n = PH_DESEL;
                    end else begin
                        ph_n  = PH_DAT_HI;
                        cnt_n = cnt - 1'b1;
                    end
                end
                PH_DESEL:   ph_n = PH_POST_HI;
                PH_POST_HI: ph_n = PH_POST_LO;
                PH_POST_LO: begin
                    ph_n   = PH_IDLE;
                    finish = 1'b1;
                end
                default:    ph_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            sr   <= '0;
            cnt  <= '0;
            pins <= '0;
        end else begin
            ph   <= ph_n;
            sr   <= sr_n;
            cnt  <= cnt_n;
            pins <= pins_for(ph_n, sr_n[SHIFT_W-1]);
        end
    end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
    import mw_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wide_dev,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    logic     run, tick, accept, take, finish;
    mw_pins_t pins;

    mw_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    mw_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .addr   (rd_addr),
        .wide   (wide_dev),
        .tick   (tick),
        .run    (run),
        .accept (accept),
        .take   (take),
        .finish (finish),
        .pins   (pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (accept)
                rd_data <= '0;
            else if (take)
                rd_data <= {rd_data[DATA_W-2:0], ee_do};
        end
    end

    assign busy  = run;
    assign ee_cs = pins.cs;
    assign ee_sk = pins.sk;
    assign ee_di = pins.di;
endmodule

// File: rtl/mw_reader_checker.sv
module mw_reader_checker #(
    parameter int SETTLE = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        ee_cs,
    input logic        ee_sk,
    input logic        ee_di
);
    localparam int AW = $clog2(SETTLE + 2);
    localparam logic [AW-1:0] AMAX = AW'(SETTLE);

    logic [2:0]    prev_pins;
    logic [AW-1:0] age;
    logic          moved;

    assign moved = ({ee_cs, ee_sk, ee_di} != prev_pins);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pins <= '0;
            age       <= '0;
        end else begin
            prev_pins <= {ee_cs, ee_sk, ee_di};
            if (moved)
                age <= AW'(1);
            else if (age != AMAX)
                age <= age + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ee_cs && !ee_sk && !ee_di && !busy && !done));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && ee_cs && !ee_sk));

    assert_stable_sk_high_R5: assert property (@(posedge clk) disable iff (rst)
        (ee_sk && $past(ee_sk)) |-> ($stable(ee_di) && $stable(ee_cs)));

    assert_di_low_deselected_R7: assert property (@(posedge clk) disable iff (rst)
        !ee_cs |-> !ee_di);

    assert_settle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (moved && $past(busy)) |-> (age >= AMAX));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_end_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(rd_data));

endmodule

bind mw_eeprom_reader mw_reader_checker #(.SETTLE(SETTLE_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .ee_cs   (ee_cs),
    .ee_sk   (ee_sk),
    .ee_di   (ee_di)
);

// File: tb/mw_eeprom_reader_tb.sv
module mw_eeprom_reader_tb;
    localparam int SETTLE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic        wide_dev = 1'b0;
    logic        busy, done, ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    mw_eeprom_reader #(.SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr),
        .wide_dev(wide_dev), .busy(busy), .done(done), .rd_data(rd_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input int a);
        logic [15:0] w;
        w = 16'(a * 16'h9E37) ^ 16'hC5A3;
        return w | 16'h8001;
    endfunction

    typedef struct {
        logic [15:0] data;
        int          rises;
        int          addr;
    } exp_t;
    exp_t exp_q[$];

    // Behavioural memory and pin observer
    int          m_state = 0;
    int          m_nbits = 0;
    logic [9:0]  m_shift = '0;
    logic [15:0] m_word = '0;
    int          m_alen = 6;
    int          m_addr = -1;
    int          m_op = -1;
    int          m_lead = 0;
    int          rises = 0;
    int          rises_desel = 0;
    int          di_moves_hi = 0;
    int          hi_len = 0;
    int          hi_bad = 0;
    int          dones = 0;
    logic        sk_prev = 0, di_prev = 0, cs_prev = 0, done_prev = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ee_sk && !sk_prev) begin
                rises++;
                if (!ee_cs) rises_desel++;
                hi_len = 1;
                if (ee_cs) begin
                    case (m_state)
                        0: if (ee_di) begin m_state = 1; m_nbits = 0; m_shift = '0; end
                           else m_lead++;
                        1: begin
                            m_shift = {m_shift[8:0], ee_di};
                            m_nbits++;
                            if (m_nbits == 2 + m_alen) begin
                                m_op   = int'(m_shift >> m_alen) & 3;
                                m_addr = int'(m_shift) & ((1 << m_alen) - 1);
                                m_word = mem_word(m_addr);
                                ee_do  = 1'b0;
                                m_state = 2;
                            end
                        end
                        default: begin
                            ee_do  = m_word[15];
                            m_word = m_word << 1;
                        end
                    endcase
                end
            end else if (ee_sk && sk_prev) begin
                hi_len++;
                if (ee_di != di_prev || ee_cs != cs_prev) di_moves_hi++;
            end else if (!ee_sk && sk_prev) begin
                if (hi_len != SETTLE) hi_bad++;
            end
            if (!ee_cs) begin
                m_state = 0;
                ee_do   = 1'b0;
            end
            sk_prev = ee_sk;
            di_prev = ee_di;
            cs_prev = ee_cs;
        end
    end

    // Monitor: pops the scoreboard on each done
    always @(negedge clk) begin
        if (!rst) begin
            if (done && done_prev)
                check(0, "R10 done wider than one cycle", 1, 0);
            if (done) begin
                dones++;
                if (exp_q.size() == 0) begin
                    check(0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rd_data == e.data, "R6 word (dummy zero skipped)", rd_data, e.data);
                    check(m_addr == e.addr, "R4 address seen by memory", m_addr, e.addr);
                    check(m_op == 2, "R3 opcode after start bit", m_op, 2);
                    check(m_lead == 1, "R3 one idle pulse before command", m_lead, 1);
                    check(rises == e.rises, "R7 total clock pulses", rises, e.rises);
                    check(rises_desel == 1, "R7 pulse after deselect", rises_desel, 1);
                    check(!busy, "R10 busy low with done", busy, 0);
                end
            end
            done_prev = done;
        end
    end

    task automatic issue(input logic [7:0] a, input logic w, input bit poke_mid);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        m_alen = w ? 8 : 6;
        m_lead = 0; rises = 0; rises_desel = 0; m_addr = -1; m_op = -1;
        e.data  = mem_word(w ? int'(a) : int'(a[5:0]));
        e.addr  = w ? int'(a) : int'(a[5:0]);
        e.rises = w ? 29 : 27;
        exp_q.push_back(e);
        rd_addr = a; wide_dev = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rd_addr = ~a; wide_dev = ~w;
        check(busy && ee_cs && !ee_sk, "R2 accept", {busy, ee_cs, ee_sk}, 3'b110);
        if (poke_mid) begin
            repeat (40) @(negedge clk);
            rd_addr = 8'h11; wide_dev = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : driver
        logic [15:0] held;
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di && !busy && !done, "R1 pins/status in reset",
              {ee_cs, ee_sk, ee_di, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 16'h0 && !busy, "R1 after reset", rd_data, 0);

        issue(8'h00, 1'b0, 0);
        issue(8'h3F, 1'b0, 0);
        issue(8'hEA, 1'b0, 0);   // R4: upper bits ignored in small mode
        issue(8'h00, 1'b1, 0);
        issue(8'hFF, 1'b1, 0);
        issue(8'h81, 1'b1, 0);
        issue(8'h15, 1'b0, 1);   // R9: start while busy
        check(dones == 7, "R9 done count", dones, 7);

        held = rd_data;
        repeat (12) @(negedge clk);
        check(rd_data == held && !done, "R10 data held while idle", rd_data, held);
        check(di_moves_hi == 0, "R5 no change with clock high", di_moves_hi, 0);
        check(hi_bad == 0, "R8 clock high phase length", hi_bad, 0);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule